// File: doc/BRIEF.md
# Quadrature Phase Shifter (Hilbert FIR)

This block takes a stream of real, signed, fixed-point samples and produces two aligned streams. The quadrature stream Q is the input passed through a fixed antisymmetric FIR kernel that shifts its phase by 90 degrees. The in-phase stream I is the input delayed to the kernel's center. Both leave on the same cycle under one valid strobe, so a later stage can form a magnitude or an envelope from each I/Q pair.

The kernel reaches `HALF` samples to each side of the center and has nonzero weights only at odd offsets. Because the weight at offset +j is the negative of the weight at offset -j, the two samples that share a weight are subtracted first. Each difference then goes through a single multiplier, so the number of multipliers is halved. A parameter chooses between truncated kernel weights and Hamming-windowed weights. Both sets are computed at elaboration. Every stage of the datapath is registered, so the latency is fixed.

Top module: `hilbert_fir`

## Requirements
- R1: `out_i` equals the input accepted `HALF` valid samples before the one that completes the output's window (zero when no such input exists since reset), and it is presented with the matching `out_q`.
- R2: With `WINDOW = WIN_RECT`, the coefficient at odd offset j is round(2/(jπ)·2^`CF`), the weight at every even offset (including the center) is zero, and the full-width accumulator for center sample m is the sum over odd j ≤ `HALF` of (x[m−j] − x[m+j])·coef(j).
- R3: With `WINDOW = WIN_HAMMING`, each coefficient is round(2/(jπ)·(0.54 + 0.46·cos(πj/(`HALF`+1)))·2^`CF`), used in the same sum.
- R4: `out_q` is the accumulator plus 2^(`CF`−1), arithmetically shifted right by `CF`, and then saturated to the signed `OW`-bit range: an accumulator ≥ (2^(`OW`−1)−1)·2^`CF` gives the maximum, and one ≤ −2^(`OW`−1)·2^`CF` gives the minimum.
- R5: `out_valid` is high exactly 4 clock edges after each edge that accepts an input with `in_valid` high, one output for each input.
- R6: Cycles with `in_valid` low leave the history unchanged, whatever `in_data` holds.
- R7: Synchronous active-high `rst` clears the history, drives `out_valid` low and `out_i`/`out_q` to zero, so the first outputs after reset see zero history.
- R8: A constant input gives `out_q` = 0 once 2·`HALF`+1 samples have been accepted.
- R9: A cosine of amplitude A with a period of about 10 samples gives `out_q` within 10% of A of the matching sine, which lags by 90 degrees.
- R10: `out_i` and `out_q` hold their values on cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | DW | Input delayed to the kernel center |
| out_q | output | OW | Phase-shifted (quadrature) sample |

## Verification
An impulse exposes each tap weight one by one. A design that uses an even tap, swaps the sign of the pair difference, or picks the wrong window would put wrong values at known positions in the output. Inputs that step hard between the rails drive the accumulator past both saturation limits, where a design that wraps instead of saturating shows a sign flip. A stream with idle cycles and junk data checks that the history only shifts on valid samples; a design that shifts on every clock would misalign both I and Q. Constant input, cosines at several periods and the zero-history start after reset are each compared against an integer model in the bench.

// File: rtl/hilb_pkg.sv
package hilb_pkg;

    typedef enum logic [0:0] {
        WIN_RECT    = 1'b0,
        WIN_HAMMING = 1'b1
    } hilb_win_e;

    localparam real PI_R = 3.14159265358979;

    // Power series for cosine, good over [0, pi] at elaboration time.
    function automatic real cos_series(real a);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int k = 1; k < 24; k++) begin
            term = -term * a * a / real'((2 * k - 1) * (2 * k));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Quantized kernel weight at odd offset j from the center.
    function automatic int tap_weight(int j, int half, int frac, hilb_win_e win);
        real w;
        w = 2.0 / (real'(j) * PI_R);
        if (win == WIN_HAMMING)
            w = w * (0.54 + 0.46 * cos_series(PI_R * real'(j) / real'(half + 1)));
        return $rtoi(w * (2.0 ** frac) + 0.5);
    endfunction

    function automatic int odd_tap_count(int half);
        return (half + 1) / 2;
    endfunction

endpackage

// File: rtl/hilb_window.sv
// History register plus pre-subtraction of mirrored pairs.
module hilb_window #(
    parameter int DW   = 12,
    parameter int HALF = 11,
    parameter int NT   = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    output logic signed [DW:0]   diff [NT],
    output logic signed [DW-1:0] center
);
    localparam int LEN = 2 * HALF + 1;

    logic signed [DW-1:0] hist [LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN; i++) hist[i] <= '0;
        end else if (shift) begin
            hist[0] <= din;
            for (int i = 1; i < LEN; i++) hist[i] <= hist[i-1];
        end
    end

    // hist[HALF+J] is older (x[m-J]), hist[HALF-J] is newer (x[m+J]).
    for (genvar k = 0; k < NT; k++) begin : g_pair
        localparam int J = 2 * k + 1;
        always_ff @(posedge clk) begin
            if (rst) diff[k] <= '0;
            else     diff[k] <= {hist[HALF+J][DW-1], hist[HALF+J]}
                              - {hist[HALF-J][DW-1], hist[HALF-J]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) center <= '0;
        else     center <= hist[HALF];
    end

endmodule

// File: rtl/hilb_mac.sv
// Constant multipliers on the pair differences, then a registered sum.
module hilb_mac #(
    parameter int                  DW     = 12,
    parameter int                  CW     = 16,
    parameter int                  CF     = 14,
    parameter int                  HALF   = 11,
    parameter hilb_pkg::hilb_win_e WINDOW = hilb_pkg::WIN_RECT,
    parameter int                  NT     = 6,
    parameter int                  AW     = 33
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW:0]   diff [NT],
    output logic signed [AW-1:0] acc
);
    localparam int PW = DW + 1 + CW;

    logic signed [PW-1:0] prod [NT];
    logic signed [AW-1:0] sum_c;

    for (genvar k = 0; k < NT; k++) begin : g_mul
        localparam int                   CINT = hilb_pkg::tap_weight(2 * k + 1, HALF, CF, WINDOW);
        localparam logic signed [CW-1:0] COEF = CW'(CINT);
        always_ff @(posedge clk) begin
            if (rst) prod[k] <= '0;
            else     prod[k] <= diff[k] * COEF;
        end
    end

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < NT; k++) sum_c = sum_c + AW'(prod[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= sum_c;
    end

endmodule

// File: rtl/hilb_round_sat.sv
// Round half up, drop CF fraction bits, clamp to OW bits; loads on strobe.
module hilb_round_sat #(
    parameter int AW = 33,
    parameter int CF = 14,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [AW-1:0] acc,
    output logic signed [OW-1:0] q
);
    localparam logic signed [AW-1:0] HALF_LSB = AW'(1) << (CF - 1);
    localparam logic signed [AW-1:0] QMAX_A   = (AW'(1) << (OW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] QMIN_A   = ~QMAX_A;
    localparam logic signed [OW-1:0] QMAX     = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] QMIN     = {1'b1, {(OW-1){1'b0}}};

    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] sh;
    logic signed [OW-1:0] q_c;

    always_comb begin
        rnd = acc + HALF_LSB;
        sh  = rnd >>> CF;
        if (sh > QMAX_A)      q_c = QMAX;
        else if (sh < QMIN_A) q_c = QMIN;
        else                  q_c = sh[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= q_c;
    end

endmodule

// File: rtl/hilbert_fir.sv
module hilbert_fir #(
    parameter int                  DW     = 12,
    parameter int                  CW     = 16,
    parameter int                  CF     = 14,
    parameter int                  OW     = 12,
    parameter int                  HALF   = 11,
    parameter hilb_pkg::hilb_win_e WINDOW = hilb_pkg::WIN_RECT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [OW-1:0] out_q
);
    localparam int NT = hilb_pkg::odd_tap_count(HALF);
    localparam int AW = DW + 1 + CW + $clog2(NT) + 1;

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] ctr;
    } tag_t;

    logic                 v_a;
    tag_t                 tag_c;
    tag_t                 tag_d;
    logic signed [DW:0]   diff [NT];
    logic signed [DW-1:0] center_b;
    logic                 v_b;
    logic signed [AW-1:0] acc_d;

    hilb_window #(.DW(DW), .HALF(HALF), .NT(NT)) u_window (
        .clk(clk), .rst(rst), .shift(in_valid), .din(in_data),
        .diff(diff), .center(center_b)
    );

    hilb_mac #(.DW(DW), .CW(CW), .CF(CF), .HALF(HALF), .WINDOW(WINDOW),
               .NT(NT), .AW(AW)) u_mac (
        .clk(clk), .rst(rst), .diff(diff), .acc(acc_d)
    );

    hilb_round_sat #(.AW(AW), .CF(CF), .OW(OW)) u_round (
        .clk(clk), .rst(rst), .load(tag_d.vld), .acc(acc_d), .q(out_q)
    );

    // Valid and center sample travel alongside the arithmetic stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_a       <= 1'b0;
            v_b       <= 1'b0;
            tag_c     <= '0;
            tag_d     <= '0;
            out_valid <= 1'b0;
            out_i     <= '0;
        end else begin
            v_a       <= in_valid;
            v_b       <= v_a;
            tag_c     <= '{vld: v_b, ctr: center_b};
            tag_d     <= tag_c;
            out_valid <= tag_d.vld;
            if (tag_d.vld) out_i <= tag_d.ctr;
        end
    end

endmodule

// File: rtl/hilbert_fir_checks.sv
module hilbert_fir_checks #(
    parameter int DW = 12,
    parameter int OW = 12,
    parameter int AW = 33,
    parameter int CF = 14
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [AW-1:0] acc,
    input logic signed [OW-1:0] out_q,
    input logic signed [DW-1:0] out_i
);
    localparam logic signed [AW-1:0] LIM_HI = ((AW'(1) << (OW - 1)) - AW'(1)) << CF;
    localparam logic signed [AW-1:0] LIM_LO = ~((AW'(1) << (OW - 1 + CF)) - AW'(1));
    localparam logic signed [OW-1:0] QMAX   = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] QMIN   = {1'b1, {(OW-1){1'b0}}};

    logic [2:0] since;
    always_ff @(posedge clk) begin
        if (rst)               since <= '0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    assert_sat_high_R4: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd2 && out_valid && $past(acc) >= LIM_HI) |-> (out_q == QMAX));

    assert_sat_low_R4: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd2 && out_valid && $past(acc) <= LIM_LO) |-> (out_q == QMIN));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_q == '0 && out_i == '0));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd1 && !out_valid) |-> ($stable(out_q) && $stable(out_i)));

endmodule

bind hilbert_fir hilbert_fir_checks #(.DW(DW), .OW(OW), .AW(AW), .CF(CF)) u_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .acc(acc_d), .out_q(out_q), .out_i(out_i)
);

// File: tb/test_hilbert_fir.sv
`timescale 1ns/1ps
module test_hilbert_fir;
    localparam int  DW = 12, CW = 16, CF = 14, OW = 12, H = 11;
    localparam int  MAXN = 512;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic ov0, ov1;
    logic signed [DW-1:0] oi0, oi1;
    logic signed [OW-1:0] oq0, oq1;

    always #5 clk = ~clk;

    hilbert_fir #(.DW(DW), .CW(CW), .CF(CF), .OW(OW), .HALF(H),
                  .WINDOW(hilb_pkg::WIN_RECT)) i_hilbert_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov0), .out_i(oi0), .out_q(oq0));

    hilbert_fir #(.DW(DW), .CW(CW), .CF(CF), .OW(OW), .HALF(H),
                  .WINDOW(hilb_pkg::WIN_HAMMING)) i_hilbert_fir_hw (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov1), .out_i(oi1), .out_q(oq1));

    int checks = 0, errors = 0;
    bit done = 0;
    int cyc = 0;
    int xin [MAXN];
    int n_in;
    int in_cyc [MAXN];
    int q0 [MAXN], i0 [MAXN], c0 [MAXN], q1 [MAXN], i1 [MAXN];
    int oc0 = 0, oc1 = 0, hold_err = 0;
    int pq0 = 0, pi0 = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            oc0 = 0; oc1 = 0; pq0 = 0; pi0 = 0;
        end else begin
            if (ov0 && oc0 < MAXN) begin
                q0[oc0] = int'(oq0); i0[oc0] = int'(oi0); c0[oc0] = cyc; oc0++;
            end
            if (!ov0 && (int'(oq0) != pq0 || int'(oi0) != pi0)) hold_err++;
            pq0 = int'(oq0); pi0 = int'(oi0);
            if (ov1 && oc1 < MAXN) begin
                q1[oc1] = int'(oq1); i1[oc1] = int'(oi1); oc1++;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int coef(int j, bit ham);
        real w;
        w = 2.0 / (real'(j) * PI);
        if (ham) w = w * (0.54 + 0.46 * $cos(PI * real'(j) / real'(H + 1)));
        return $rtoi(w * 16384.0 + 0.5);
    endfunction

    function automatic int xv(int idx);
        return (idx < 0) ? 0 : xin[idx];
    endfunction

    function automatic int model_q(int k, bit ham);
        longint acc = 0;
        longint r;
        for (int j = 1; j <= H; j += 2)
            acc += longint'(xv(k - H - j) - xv(k - H + j)) * coef(j, ham);
        r = (acc + 8192) >>> CF;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return int'(r);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(bit gaps);
        for (int n = 0; n < n_in; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(xin[n]);
            in_cyc[n] = cyc + 1;
            if (gaps && (n % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 12'sh5A5;
                if (n % 2 == 0) begin
                    @(negedge clk);
                    in_data = -12'sd777;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic compare(string tag);
        check("R5", {tag, " output count rect"}, oc0, n_in);
        check("R5", {tag, " output count hamming"}, oc1, n_in);
        for (int k = 0; k < n_in && k < oc0 && k < oc1; k++) begin
            check("R2", {tag, " rect Q"}, q0[k], model_q(k, 1'b0));
            check("R3", {tag, " hamming Q"}, q1[k], model_q(k, 1'b1));
            check("R1", {tag, " I rect"}, i0[k], xv(k - H));
            check("R1", {tag, " I hamming"}, i1[k], xv(k - H));
            check("R5", {tag, " latency"}, c0[k] - in_cyc[k], 4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] s;
        // R7: reset state
        do_reset();
        @(negedge clk);
        check("R7", "out_valid after reset", int'(ov0), 0);
        check("R7", "out_q after reset", int'(oq0), 0);
        check("R7", "out_i after reset", int'(oi0), 0);
        check("R7", "hamming out_q after reset", int'(oq1), 0);

        // Impulse exposes each tap (R2, R3); zero history after reset (R7)
        n_in = 40;
        for (int n = 0; n < n_in; n++) xin[n] = (n == 0) ? 1000 : 0;
        do_reset(); feed(1'b0); compare("impulse");
        // Output at center k-H = +j gives x[m-j]=1000 -> positive weight; center -j negative
        check("R2", "impulse tap j=1 after", q0[H + 1], (1000 * coef(1, 1'b0) + 8192) >>> CF);
        check("R2", "even tap j=2 zero", q0[H + 2], 0);
        check("R2", "center tap zero", q0[H], 0);
        check("R7", "first output zero history", q0[0], model_q(0, 1'b0));

        // Cosines at several periods (R9 on the period near 10)
        n_in = 120;
        for (int n = 0; n < n_in; n++) xin[n] = int'(1500.0 * $cos(2.0 * PI * n / 10.3));
        do_reset(); feed(1'b0); compare("cos10");
        for (int k = 2 * H; k < n_in; k++) begin
            int e, d;
            e = int'(1500.0 * $sin(2.0 * PI * (k - H) / 10.3));
            d = q0[k] - e;
            if (d < 0) d = -d;
            check("R9", "sine lag within 150", (d <= 150) ? 1 : 0, 1);
        end
        for (int n = 0; n < n_in; n++) xin[n] = int'(1000.0 * $cos(2.0 * PI * n / 4.0));
        do_reset(); feed(1'b0); compare("cos4");
        for (int n = 0; n < n_in; n++) xin[n] = int'(1800.0 * $cos(2.0 * PI * n / 37.0));
        do_reset(); feed(1'b0); compare("cos37");

        // DC (R8)
        n_in = 60;
        for (int n = 0; n < n_in; n++) xin[n] = 1000;
        do_reset(); feed(1'b0); compare("dc");
        for (int k = 2 * H; k < n_in; k++) begin
            check("R8", "dc rect Q zero", q0[k], 0);
            check("R8", "dc hamming Q zero", q1[k], 0);
        end

        // Rail steps drive both saturation limits (R4)
        n_in = 90;
        for (int n = 0; n < n_in; n++) xin[n] = (n < 30 || n >= 60) ? 2047 : -2048;
        do_reset(); feed(1'b0); compare("sat");
        check("R4", "positive saturation", q0[30 + H], 2047);
        check("R4", "negative saturation", q0[60 + H], -2048);

        // Random data with idle cycles carrying junk (R6, R10)
        n_in = 200;
        s = 32'h1234_5678;
        for (int n = 0; n < n_in; n++) begin
            s = s * 32'd1103515245 + 32'd12345;
            xin[n] = int'(s[27:16]) - 2048;
        end
        hold_err = 0;
        do_reset(); feed(1'b1); compare("gaps_R6");
        check("R10", "outputs held while out_valid low", hold_err, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule